// File: doc/BRIEF.md
# Snoop Response Combiner with Memory Response Gate

This unit sits on a shared, atomic bus and collects the snoop replies of every cache for the transaction in flight. Each cache reports three things: it holds a copy, it holds a modified copy, and its snoop lookup is still busy. The unit ORs each kind across all caches into a bus-wide result line. It keeps main memory from answering until the snoop outcome is known.

Once the outcome is known, the unit picks the data source. A modified copy makes the owning cache supply the data, and memory is held off. An exclusive read that finds the line shared elsewhere needs no data at all, so memory is also held off. This takes the place of a separate upgrade transaction. In every other case memory answers.

Snoop completion can be detected in one of two ways, chosen per transaction. In the variable mode, the unit waits for the busy line to drop. In the fixed mode, it samples after a set number of cycles and flags a protocol error if any cache is still busy at that point.

Top module: `snoop_combiner`

## Requirements
- R1: `line_shared_o` equals the OR of all `snp_shared_i` bits in the same cycle.
- R2: `line_dirty_o` equals the OR of all `snp_dirty_i` bits in the same cycle.
- R3: `line_busy_o` equals the OR of all `snp_busy_i` bits in the same cycle.
- R4: `addr_ready_o` is 1 while no transaction is open. An address phase is a cycle with `addr_valid_i` and `addr_ready_o` both high. After an address phase, `addr_ready_o` stays 0 until the grant cycle, so only one transaction is open at a time. `addr_valid_i` is ignored while `addr_ready_o` is 0.
- R5: In variable mode (`lat_fixed_i`=0 at the address phase), snooping ends in the first cycle after the address phase in which `line_busy_o` is 0. `grant_valid_o` pulses for one cycle in the cycle that follows.
- R6: The shared and modified lines are used only in the cycle in which snooping ends. Values they carry in earlier cycles have no effect on the grant.
- R7: If `line_dirty_o` is 1 when snooping ends, `grant_src_o` is 2'b01 (cache supplies the data). `grant_owner_o` is then the lowest index whose `snp_dirty_i` bit is set.
- R8: If the modified line is 0, the shared line is 1 and the transaction is an exclusive read (`excl_rd_i`=1 at the address phase), memory is suppressed and `grant_src_o` is 2'b10 (no data).
- R9: In all other cases `grant_src_o` is 2'b00 (memory supplies the data).
- R10: In fixed mode (`lat_fixed_i`=1 at the address phase), snooping ends exactly FIX_LAT cycles after the address phase, whatever the busy line shows. The grant follows in the next cycle.
- R11: `proto_err_o` pulses together with `grant_valid_o` exactly when a fixed-mode transaction sees `line_busy_o` high in the cycle snooping ends. It is 0 for variable-mode transactions.
- R12: While reset is held and directly after it, `addr_ready_o` is 1, and `grant_valid_o` and `proto_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | Address phase request |
| excl_rd_i | input | 1 | Transaction is an exclusive read (taken at address phase) |
| lat_fixed_i | input | 1 | Use fixed snoop latency for this transaction (taken at address phase) |
| snp_shared_i | input | N_CACHE | Per-cache has-copy reply |
| snp_dirty_i | input | N_CACHE | Per-cache has-modified-copy reply |
| snp_busy_i | input | N_CACHE | Per-cache snoop-still-running reply |
| addr_ready_o | output | 1 | New address phase can be accepted |
| line_shared_o | output | 1 | Wired-OR has-copy line |
| line_dirty_o | output | 1 | Wired-OR modified line |
| line_busy_o | output | 1 | Wired-OR snoop-pending line |
| grant_valid_o | output | 1 | One-cycle data-phase grant |
| grant_src_o | output | 2 | Data source: 00 memory, 01 cache, 10 none |
| grant_owner_o | output | ID_W | Supplying cache index when source is cache |
| proto_err_o | output | 1 | Fixed-mode snoop still pending at sample point |

## Verification
The case that is hardest to reach from the ports is a late owner. In that case, the shared and modified lines carry misleading values through a long busy stretch and change only in the cycle the busy line drops. The stimulus fills every snoop cycle before the end with random replies, including modified bits, and places the real answer only in the final cycle. The fixed-mode error needs the busy line raised in exactly the sample cycle, so the bench steers it there on purpose. A repeated address request held through the snoop window confirms that the unit never opens a second transaction.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    SRC_MEM   = 2'b00,
    SRC_CACHE = 2'b01,
    SRC_NONE  = 2'b10
  } data_src_e;
endpackage

// File: rtl/snoop_reduce.sv
module snoop_reduce #(
  parameter int N_CACHE = 4,
  localparam int ID_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic [N_CACHE-1:0] shared_i,
  input  logic [N_CACHE-1:0] dirty_i,
  input  logic [N_CACHE-1:0] busy_i,
  output logic               any_shared_o,
  output logic               any_dirty_o,
  output logic               any_busy_o,
  output logic [ID_W-1:0]    owner_o
);
  assign any_shared_o = |shared_i;
  assign any_dirty_o  = |dirty_i;
  assign any_busy_o   = |busy_i;

  // lowest-index owner wins
  always_comb begin
    owner_o = '0;
    for (int i = N_CACHE-1; i >= 0; i--) begin
      if (dirty_i[i]) owner_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int FIX_LAT = 4,
  parameter int ID_W    = 2,
  localparam int CNT_W  = $clog2(FIX_LAT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_valid_i,
  input  logic            excl_rd_i,
  input  logic            lat_fixed_i,
  input  logic            any_shared_i,
  input  logic            any_dirty_i,
  input  logic            any_busy_i,
  input  logic [ID_W-1:0] owner_i,
  output logic            addr_ready_o,
  output logic            grant_valid_o,
  output logic [1:0]      grant_src_o,
  output logic [ID_W-1:0] grant_owner_o,
  output logic            proto_err_o
);
  typedef enum logic {ST_IDLE, ST_SNOOP} state_e;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             excl_q, fix_q;
  logic             gnt_q, err_q;
  data_src_e        src_q;
  logic [ID_W-1:0]  own_q;
  logic             sample_now;
  data_src_e        src_d;

  assign sample_now = fix_q ? (cnt_q == CNT_W'(FIX_LAT)) : !any_busy_i;

  always_comb begin
    if (any_dirty_i)                src_d = SRC_CACHE;
    else if (excl_q && any_shared_i) src_d = SRC_NONE;
    else                            src_d = SRC_MEM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      excl_q  <= 1'b0;
      fix_q   <= 1'b0;
      gnt_q   <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= SRC_MEM;
      own_q   <= '0;
    end else begin
      gnt_q <= 1'b0;
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (addr_valid_i) begin
            state_q <= ST_SNOOP;
            cnt_q   <= CNT_W'(1);
            excl_q  <= excl_rd_i;
            fix_q   <= lat_fixed_i;
          end
        end
        ST_SNOOP: begin
          if (sample_now) begin
            state_q <= ST_IDLE;
            gnt_q   <= 1'b1;
            src_q   <= src_d;
            own_q   <= owner_i;
            err_q   <= fix_q && any_busy_i;
          end else if (cnt_q != CNT_W'(FIX_LAT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_ready_o  = (state_q == ST_IDLE);
  assign grant_valid_o = gnt_q;
  assign grant_src_o   = src_q;
  assign grant_owner_o = own_q;
  assign proto_err_o   = err_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ready_o && addr_valid_i) |=> !addr_ready_o); // R4
  AST_GRANT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |=> !grant_valid_o); // R5
  AST_GRANT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> addr_ready_o); // R4
  AST_SRC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_src_o != 2'b11)); // R9
endmodule

// File: rtl/snoop_combiner.sv
module snoop_combiner
  import snoop_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int FIX_LAT = 4,
  localparam int ID_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_valid_i,
  input  logic               excl_rd_i,
  input  logic               lat_fixed_i,
  input  logic [N_CACHE-1:0] snp_shared_i,
  input  logic [N_CACHE-1:0] snp_dirty_i,
  input  logic [N_CACHE-1:0] snp_busy_i,
  output logic               addr_ready_o,
  output logic               line_shared_o,
  output logic               line_dirty_o,
  output logic               line_busy_o,
  output logic               grant_valid_o,
  output logic [1:0]         grant_src_o,
  output logic [ID_W-1:0]    grant_owner_o,
  output logic               proto_err_o
);
  logic [ID_W-1:0] owner;

  snoop_reduce #(.N_CACHE(N_CACHE)) u_reduce (
    .shared_i     (snp_shared_i),
    .dirty_i      (snp_dirty_i),
    .busy_i       (snp_busy_i),
    .any_shared_o (line_shared_o),
    .any_dirty_o  (line_dirty_o),
    .any_busy_o   (line_busy_o),
    .owner_o      (owner)
  );

  snoop_ctrl #(.FIX_LAT(FIX_LAT), .ID_W(ID_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_valid_i  (addr_valid_i),
    .excl_rd_i     (excl_rd_i),
    .lat_fixed_i   (lat_fixed_i),
    .any_shared_i  (line_shared_o),
    .any_dirty_i   (line_dirty_o),
    .any_busy_i    (line_busy_o),
    .owner_i       (owner),
    .addr_ready_o  (addr_ready_o),
    .grant_valid_o (grant_valid_o),
    .grant_src_o   (grant_src_o),
    .grant_owner_o (grant_owner_o),
    .proto_err_o   (proto_err_o)
  );

  AST_WAIT_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !proto_err_o) |-> !$past(line_busy_o)); // R5
  AST_DIRTY_INHIBITS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && $past(line_dirty_o)) |-> (grant_src_o == 2'b01)); // R7
  AST_SUPPRESS_NEEDS_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && grant_src_o == 2'b10) |-> ($past(line_shared_o) && !$past(line_dirty_o))); // R8
  AST_ERR_WITH_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (grant_valid_o && $past(line_busy_o))); // R11
endmodule

// File: tb/snoop_combiner_bench.sv
module snoop_combiner_bench;
  localparam int N  = 4;
  localparam int K  = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic av = 1'b0, ex = 1'b0, fx = 1'b0;
  logic [N-1:0] sh = '0, dr = '0, bz = '0;
  logic ready, l_sh, l_dr, l_bz, gv, perr;
  logic [1:0] src;
  logic [IW-1:0] own;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  snoop_combiner #(.N_CACHE(N), .FIX_LAT(K)) u_snoop_combiner (
    .clk_i(clk), .rst_ni(rst_n), .addr_valid_i(av), .excl_rd_i(ex), .lat_fixed_i(fx),
    .snp_shared_i(sh), .snp_dirty_i(dr), .snp_busy_i(bz),
    .addr_ready_o(ready), .line_shared_o(l_sh), .line_dirty_o(l_dr), .line_busy_o(l_bz),
    .grant_valid_o(gv), .grant_src_o(src), .grant_owner_o(own), .proto_err_o(perr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_src(input bit e, input logic [N-1:0] s, input logic [N-1:0] d);
    if (d != 0) return 1;
    if (e && s != 0) return 2;
    return 0;
  endfunction

  function automatic int low_idx(input logic [N-1:0] d);
    for (int i = 0; i < N; i++) if (d[i]) return i;
    return 0;
  endfunction

  task automatic chk_lines();
    chk(l_sh == |sh, "R1", int'(l_sh), int'(|sh));
    chk(l_dr == |dr, "R2", int'(l_dr), int'(|dr));
    chk(l_bz == |bz, "R3", int'(l_bz), int'(|bz));
  endtask

  function automatic logic [N-1:0] rnd();
    return N'($urandom_range(0, (1 << N) - 1));
  endfunction

  function automatic logic [N-1:0] rnd_nz();
    return N'($urandom_range(1, (1 << N) - 1));
  endfunction

  task automatic run_txn(input bit e, input bit f, input int wait_n,
                         input logic [N-1:0] fs, input logic [N-1:0] fd,
                         input bit berr, input bit hold);
    int ncyc;
    ncyc = f ? K : wait_n + 1;
    @(negedge clk);
    av = 1'b1; ex = e; fx = f; sh = rnd(); dr = rnd(); bz = rnd();
    #1;
    chk(ready == 1'b1, "R4 ready idle", int'(ready), 1);
    chk_lines();
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      av = hold; ex = $urandom_range(0, 1); fx = $urandom_range(0, 1);
      if (c < ncyc) begin
        sh = rnd(); dr = rnd();
        bz = f ? rnd() : rnd_nz();
      end else begin
        sh = fs; dr = fd;
        bz = (f && berr) ? rnd_nz() : '0;
      end
      #1;
      chk(ready == 1'b0, "R4 busy", int'(ready), 0);
      chk(gv == 1'b0, f ? "R10 early grant" : "R5 early grant", int'(gv), 0);
      chk_lines();
    end
    @(negedge clk);
    av = 1'b0; sh = rnd(); dr = rnd(); bz = rnd();
    #1;
    chk(gv == 1'b1, f ? "R10 grant" : "R5 grant", int'(gv), 1);
    chk(int'(src) == exp_src(e, fs, fd), "R6/R7/R8/R9 src", int'(src), exp_src(e, fs, fd));
    if (fd != 0) chk(int'(own) == low_idx(fd), "R7 owner", int'(own), low_idx(fd));
    chk(perr == (f && berr), "R11 err", int'(perr), int'(f && berr));
    chk(ready == 1'b1, "R4 ready at grant", int'(ready), 1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    #1;
    chk(ready == 1'b1, "R12 ready", int'(ready), 1);
    chk(gv == 1'b0, "R12 grant", int'(gv), 0);
    chk(perr == 1'b0, "R12 err", int'(perr), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(ready == 1'b1 && gv == 1'b0, "R12 after reset", int'(gv), 0);
    // directed
    run_txn(0, 0, 0, 4'b0000, 4'b0000, 0, 0);   // R9 memory, no wait
    run_txn(0, 0, 5, 4'b1010, 4'b1010, 0, 0);   // R7 owner 1
    run_txn(1, 0, 3, 4'b0100, 4'b0000, 0, 0);   // R8 suppressed
    run_txn(1, 0, 2, 4'b0000, 4'b0000, 0, 1);   // R9 excl miss, R4 held request
    run_txn(0, 0, 4, 4'b0011, 4'b0000, 0, 0);   // R9 shared non-excl
    run_txn(1, 0, 6, 4'b1111, 4'b1000, 0, 0);   // R7 beats R8, owner 3
    run_txn(0, 1, 0, 4'b0001, 4'b0000, 0, 0);   // R10 fixed clean
    run_txn(1, 1, 0, 4'b0010, 4'b0000, 1, 1);   // R11 error, R8
    run_txn(0, 1, 0, 4'b0000, 4'b0100, 1, 0);   // R11 error, R7
    // random
    for (int t = 0; t < 200; t++) begin
      run_txn($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7),
              rnd(), ($urandom_range(0, 2) == 0) ? rnd() : '0,
              $urandom_range(0, 1), $urandom_range(0, 1));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule